// File: doc/BRIEF.md
# Link power latency configuration register

A 16-bit configuration word holding the link power-management latency settings of a switch port. It has three 3-bit fields: the acceptable L0s latency, the acceptable L1 latency and the L0s exit latency. The fields can be changed in two ways. Software writes them through a word-wide port with byte enables. A serial configuration memory loads them through a full-word load strobe. A fundamental reset returns every field to its default value. Each field is also driven straight out to the capability register that mirrors it.

The exit-latency field has its own behaviour. After reset it is not stored; it follows the common-clock configuration input. It reads 011 in common-clock mode and 100 otherwise. A sticky flag records whether software or the memory has put a different value into this field. Once the flag is set, the field holds the last value written and ignores the clock mode. Only the fundamental reset clears the flag again.

Top module: `lnk_pm_lat_reg`

## Requirements
- R1: The read word has the L0s acceptable latency at bits 13:11, the L1 acceptable latency at bits 10:8 and the L0s exit latency at bits 5:3. Bits 15:14, 7:6 and 2:0 always read as zero.
- R2: While rst_ni is low, and at release, both acceptable-latency fields are 000, the written flag is clear and the exit-latency field is 100.
- R3: A software write with sw_be_i[1] set loads bits 13:11 and 10:8 of sw_wdata_i into the two acceptable-latency fields on the next clock edge. With no write, those fields hold their values.
- R4: A write to the exit-latency field whose value differs from the current field value stores that value on the next clock edge and sets the written flag.
- R5: The written flag stays set until the next fundamental reset. After a reset the field tracks the clock mode again.
- R6: While the flag is clear, the exit-latency field becomes 011 one clock edge after ccc_i is 1, and 100 one edge after ccc_i is 0.
- R7: While the flag is set, the exit-latency field holds its last written value whatever ccc_i does.
- R8: A write, from software or from the load port, whose exit-latency value equals the current field value leaves the flag clear. The field then keeps tracking ccc_i.
- R9: ld_valid_i loads all three fields from ld_data_i, at the same bit positions as R1, regardless of byte enables. In a cycle with both a load and a software write, the load is applied and the software write is dropped.
- R10: sw_be_i[1] enables bits 15:8, which hold the acceptable latencies. sw_be_i[0] enables bits 7:0, which hold the exit latency. A disabled lane is left unchanged even when its data differs.
- R11: l0s_acc_lat_o, l1_acc_lat_o and l0s_exit_lat_o always equal the corresponding fields of sw_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Fundamental reset, active low, asynchronous |
| ccc_i | input | 1 | Common-clock configuration mode |
| sw_we_i | input | 1 | Software write strobe |
| sw_be_i | input | 2 | Software byte enables (bit 1: 15:8, bit 0: 7:0) |
| sw_wdata_i | input | 16 | Software write data |
| ld_valid_i | input | 1 | Serial configuration memory load strobe |
| ld_data_i | input | 16 | Load data |
| sw_rdata_o | output | 16 | Register read value |
| l0s_acc_lat_o | output | 3 | Acceptable L0s latency to device capability mirror |
| l1_acc_lat_o | output | 3 | Acceptable L1 latency to device capability mirror |
| l0s_exit_lat_o | output | 3 | L0s exit latency to link capability mirror |

## Verification
The assertions assume that every input holds a known 0/1 value at each rising edge. They also assume the load strobe and the software strobe are each sampled once per edge; no handshake is required. Nothing else is assumed: ccc_i may toggle in any cycle, and loads may coincide with software writes. The bench changes inputs only on falling edges. It steps through directed cases, in particular equal-value writes, disabled byte lanes and coinciding writes. It then runs a long random phase in which ccc_i, the strobes and the data vary together. Exit values are drawn from the two tracking codes more often than the rest, so that equal-value writes occur often.

// File: rtl/lnk_pm_lat_pkg.sv
package lnk_pm_lat_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANE  = DATA_W / LANE_W;
  localparam int unsigned N_ACC   = 2;

  // acceptable-latency fields: index 0 = L0s, 1 = L1
  localparam int unsigned ACC_LSB [N_ACC] = '{11, 8};
  localparam int unsigned ACC_LANE         = 1;
  localparam int unsigned EXIT_LSB         = 3;
  localparam int unsigned EXIT_LANE        = 0;

  localparam logic [FIELD_W-1:0] ACC_RST   = '0;
  localparam logic [FIELD_W-1:0] EXIT_CCC  = 3'b011;
  localparam logic [FIELD_W-1:0] EXIT_NCCC = 3'b100;

  typedef logic [FIELD_W-1:0] lat_t;
endpackage

// File: rtl/lat_field.sv
module lat_field
  import lnk_pm_lat_pkg::*;
#(
  parameter int unsigned W       = FIELD_W,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST_VAL;
    else if (we_i) q_q <= d_i;
  end

  assign q_o = q_q;

  assert_acc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  assert_acc_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/exit_lat_track.sv
module exit_lat_track
  import lnk_pm_lat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ccc_i,
  input  logic wr_i,
  input  lat_t d_i,
  output lat_t q_o,
  output logic written_o
);
  lat_t q_q;
  logic written_q;
  logic set_c;
  lat_t track_c;

  // only a value change latches the field
  assign set_c   = wr_i && (d_i != q_q);
  assign track_c = ccc_i ? EXIT_CCC : EXIT_NCCC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q       <= EXIT_NCCC;
      written_q <= 1'b0;
    end else if (set_c) begin
      q_q       <= d_i;
      written_q <= 1'b1;
    end else if (!written_q) begin
      q_q       <= track_c;
    end
  end

  assign q_o       = q_q;
  assign written_o = written_q;

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    written_o |=> written_o);
  assert_set_on_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (d_i != q_o)) |=> (written_o && (q_o == $past(d_i))));
  assert_track_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!written_o && !(wr_i && (d_i != q_o))) |=>
      (q_o == ($past(ccc_i) ? EXIT_CCC : EXIT_NCCC)));
  assert_hold_written_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (written_o && !wr_i) |=> $stable(q_o));
  assert_equal_keeps_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!written_o && wr_i && (d_i == q_o)) |=> !written_o);
endmodule

// File: rtl/lnk_pm_lat_reg.sv
module lnk_pm_lat_reg
  import lnk_pm_lat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ccc_i,
  input  logic              sw_we_i,
  input  logic [N_LANE-1:0] sw_be_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic              ld_valid_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [DATA_W-1:0] sw_rdata_o,
  output logic [FIELD_W-1:0] l0s_acc_lat_o,
  output logic [FIELD_W-1:0] l1_acc_lat_o,
  output logic [FIELD_W-1:0] l0s_exit_lat_o
);
  logic [DATA_W-1:0] src_c;
  logic [N_LANE-1:0] lane_we_c;
  lat_t              acc_q [N_ACC];
  lat_t              exit_q;
  logic              written;
  logic              unused_written;

  // load has priority and covers all lanes
  assign src_c = ld_valid_i ? ld_data_i : sw_wdata_i;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    assign lane_we_c[l] = ld_valid_i | (sw_we_i & sw_be_i[l]);
  end

  for (genvar a = 0; a < N_ACC; a++) begin : g_acc
    lat_field #(.W(FIELD_W), .RST_VAL(ACC_RST)) i_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (lane_we_c[ACC_LANE]),
      .d_i    (src_c[ACC_LSB[a] +: FIELD_W]),
      .q_o    (acc_q[a])
    );
  end

  exit_lat_track i_exit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ccc_i     (ccc_i),
    .wr_i      (lane_we_c[EXIT_LANE]),
    .d_i       (src_c[EXIT_LSB +: FIELD_W]),
    .q_o       (exit_q),
    .written_o (written)
  );
  assign unused_written = written;

  always_comb begin
    sw_rdata_o = '0;
    for (int a = 0; a < N_ACC; a++) sw_rdata_o[ACC_LSB[a] +: FIELD_W] = acc_q[a];
    sw_rdata_o[EXIT_LSB +: FIELD_W] = exit_q;
  end

  assign l0s_acc_lat_o  = acc_q[0];
  assign l1_acc_lat_o   = acc_q[1];
  assign l0s_exit_lat_o = exit_q;

  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> ((l0s_acc_lat_o == $past(ld_data_i[13:11])) &&
                    (l1_acc_lat_o  == $past(ld_data_i[10:8]))));
  assert_lane_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !ld_valid_i && !sw_be_i[1]) |=> ($stable(l0s_acc_lat_o) && $stable(l1_acc_lat_o)));
  assert_rsvd_mirror_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rdata_o[15:14] == 2'b00) && (sw_rdata_o[7:6] == 2'b00) && (sw_rdata_o[2:0] == 3'b000));
endmodule

// File: tb/test_lnk_pm_lat_reg.sv
`timescale 1ns/1ps
module test_lnk_pm_lat_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ccc = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_be = 2'b00;
  logic [15:0] sw_wdata = '0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_data = '0;
  logic [15:0] rdata;
  logic [2:0]  l0s_acc, l1_acc, l0s_exit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int m_l0s, m_l1, m_exit;
  bit m_wr;

  always #4 clk = ~clk;

  lnk_pm_lat_reg i_lnk_pm_lat_reg (
    .clk_i(clk), .rst_ni(rst_ni), .ccc_i(ccc),
    .sw_we_i(sw_we), .sw_be_i(sw_be), .sw_wdata_i(sw_wdata),
    .ld_valid_i(ld_valid), .ld_data_i(ld_data),
    .sw_rdata_o(rdata), .l0s_acc_lat_o(l0s_acc), .l1_acc_lat_o(l1_acc),
    .l0s_exit_lat_o(l0s_exit)
  );

  function automatic logic [15:0] word(int a, int b, int e);
    word = '0;
    word[13:11] = a[2:0];
    word[10:8]  = b[2:0];
    word[5:3]   = e[2:0];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " word"}, rdata, word(m_l0s, m_l1, m_exit));
    chk("R1 reserved", rdata & 16'hC0C7, 0);
    chk("R11 l0s mirror", l0s_acc, m_l0s);
    chk("R11 l1 mirror", l1_acc, m_l1);
    chk("R11 exit mirror", l0s_exit, m_exit);
  endtask

  task automatic model_reset();
    m_l0s = 0; m_l1 = 0; m_exit = 4; m_wr = 0;
  endtask

  task automatic model_edge();
    bit ew; int ev;
    ew = 0; ev = 0;
    if (ld_valid) begin
      m_l0s = ld_data[13:11]; m_l1 = ld_data[10:8];
      ew = 1; ev = ld_data[5:3];
    end else if (sw_we) begin
      if (sw_be[1]) begin m_l0s = sw_wdata[13:11]; m_l1 = sw_wdata[10:8]; end
      if (sw_be[0]) begin ew = 1; ev = sw_wdata[5:3]; end
    end
    if (ew && ev != m_exit) begin m_exit = ev; m_wr = 1; end
    else if (!m_wr) m_exit = ccc ? 3 : 4;
  endtask

  task automatic step(bit we, logic [1:0] be, logic [15:0] wd, bit ld, logic [15:0] ldd,
                      bit c, string tag);
    sw_we = we; sw_be = be; sw_wdata = wd; ld_valid = ld; ld_data = ldd; ccc = c;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(string tag);
    rst_ni = 1'b0;
    sw_we = 0; ld_valid = 0;
    model_reset();
    #1;
    compare(tag);
    @(negedge clk);
    @(negedge clk);
    compare(tag);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset("R2 reset");
    step(0, 2'b00, 16'h0, 0, 16'h0, 0, "R2 idle after release");
    step(0, 2'b00, 16'h0, 0, 16'h0, 1, "R6 ccc high");
    step(0, 2'b00, 16'h0, 0, 16'h0, 0, "R6 ccc low");
    step(0, 2'b00, 16'h0, 0, 16'h0, 1, "R6 ccc high again");
    step(1, 2'b10, word(5, 2, 7) | 16'hC0C7, 0, 16'h0, 1, "R10 upper lane only");
    step(1, 2'b10, word(3, 6, 0), 0, 16'h0, 1, "R3 acc write");
    step(0, 2'b00, word(7, 7, 7), 0, 16'h0, 1, "R3 hold without write");
    step(1, 2'b01, word(1, 1, 3), 0, 16'h0, 1, "R8 equal exit write");
    step(0, 2'b00, 16'h0, 0, 16'h0, 0, "R8 still tracking");
    step(1, 2'b11, word(2, 4, 6), 0, 16'h0, 0, "R4 differing exit write");
    step(0, 2'b00, 16'h0, 0, 16'h0, 1, "R7 hold on ccc high");
    step(0, 2'b00, 16'h0, 0, 16'h0, 0, "R7 hold on ccc low");
    step(1, 2'b01, word(0, 0, 4), 0, 16'h0, 1, "R7 rewrite to 100");
    step(0, 2'b00, 16'h0, 0, 16'h0, 1, "R5 flag stays set");
    step(1, 2'b11, word(6, 6, 6), 1, word(1, 7, 2), 1, "R9 load beats write");
    step(0, 2'b00, 16'h0, 1, word(4, 3, 2) | 16'hC0C7, 0, "R9 load all fields");
    @(negedge clk);
    do_reset("R5 reset clears flag");
    step(0, 2'b00, 16'h0, 0, 16'h0, 1, "R5 tracking after reset");
    step(0, 2'b00, 16'h0, 1, word(2, 5, 3), 1, "R8 equal value load");
    step(0, 2'b00, 16'h0, 0, 16'h0, 0, "R8 tracking after load");
    step(0, 2'b00, 16'h0, 1, word(2, 5, 1), 0, "R9 load sets flag");
    step(0, 2'b00, 16'h0, 0, 16'h0, 1, "R7 after load");
    @(negedge clk);
    do_reset("R2 reset again");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wd, lw;
      wd = 16'($urandom);
      lw = 16'($urandom);
      if ($urandom_range(0, 2) != 0) wd[5:3] = $urandom_range(3, 4);
      if ($urandom_range(0, 2) != 0) lw[5:3] = $urandom_range(3, 4);
      step($urandom_range(0, 3) == 0, 2'($urandom), wd,
           $urandom_range(0, 15) == 0, lw, $urandom_range(0, 1), "R11 random");
      if ($urandom_range(0, 199) == 0) begin
        @(negedge clk);
        do_reset("R5 random reset");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule